// File: doc/BRIEF.md
# Windowed Watchdog Timer

This peripheral supervises software with a countdown that must be restarted inside a time window. A 12-bit counter steps down once per pulse of a 256 Hz tick enable, so the longest reload of 0xFFF ticks lasts about sixteen seconds. Software must restart the counter before it runs out, but not too soon. A restart issued while the count is still above a programmed window delta counts as a fault, and so does running past zero.

Software reaches the block over a single-cycle register bus with a two-bit word address. A mode register takes one write after reset and then locks. It holds the reload value, the window delta, the fault actions and the freeze options. A fault sets a sticky bit in a status register, which is cleared by reading it. A fault can raise a level interrupt and can request a one-tick reset pulse, either for the processor alone or for the whole system. A disable bit turns the watchdog off entirely. Two halt bits freeze the count while the idle input or the debug input is high.

Top module: `winwdog_top`

## Requirements
- R1: After reset the mode register (address 1) reads 0x3FFF2FFF, the status register (address 2) reads 0, the count (address 3) reads 0xFFF, and irqOut, procRstOut and sysRstOut are low. Address 0 reads 0.
- R2: Only the first write to the mode register after reset takes effect. Later writes are ignored, and both the mode value and the count stay as they were. The write that is accepted reloads the count from the new reload field, bits [11:0].
- R3: While the watchdog is enabled and not halted, each tickEn pulse lowers the count by one.
- R4: A write to address 0 with 0xA5 in bits [31:24] and bit 0 set is a restart, and it reloads the count from mode bits [11:0]. A write with any other key value changes neither the count nor the status.
- R5: A restart accepted while the count is greater than the window delta (mode bits [27:16]) sets status bit 1. A restart with the count at or below the delta sets no status bit.
- R6: A tick that arrives while the count is 0 sets status bit 0 and reloads the count from mode bits [11:0].
- R7: Reading the status register returns the fault bits and clears them. irqOut is high exactly while mode bit 12 is set and the status register is nonzero.
- R8: When mode bit 13 is set, a fault raises a reset pulse from the cycle after the fault until the cycle after the next tick. Mode bit 14 sends the pulse to procRstOut; when bit 14 is clear the pulse goes to sysRstOut.
- R9: When mode bit 15 is set, the count is frozen, restarts are ignored, and no fault is reported.
- R10: The count does not change on a tick while mode bit 29 is set and idleIn is high, or while mode bit 28 is set and dbgIn is high.
- R11: A restart and a tick in the same cycle count as a restart: the count reloads and no underflow is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Word address: 0 control, 1 mode, 2 status, 3 count |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as the access |
| tickEn | input | 1 | 256 Hz count enable, one clock wide |
| idleIn | input | 1 | System idle indication |
| dbgIn | input | 1 | Debugger halt indication |
| irqOut | output | 1 | Fault interrupt, level |
| procRstOut | output | 1 | Processor-only reset request pulse |
| sysRstOut | output | 1 | Full system reset request pulse |

## Verification
The assertions assume that tickEn is a single-cycle pulse and that bus inputs are meaningful only while busSel is high. They also assume that a status read is a plain access with no write data, so the only things that can change the status are a fault or a read. The stimulus keeps to these assumptions. It drives each bus access for exactly one cycle and each tick as one isolated pulse, and it changes every input at the falling edge. It overlaps a tick with a restart only in the one case that checks their priority.

// File: rtl/winwdog_pkg.sv
package winwdog_pkg;
  localparam int unsigned CNT_W = 12;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic             countEn;
    logic             reload;
    logic [CNT_W-1:0] loadVal;
  } dpStrobe_t;
endpackage

// File: rtl/winwdog_dp.sv
module winwdog_dp
  import winwdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        str,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_INIT = '1;

  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= CNT_INIT;
    else if (str.reload) cnt <= str.loadVal;
    else if (str.countEn) cnt <= cnt - 1'b1;
  end

  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    str.reload |=> cnt == $past(str.loadVal));
  p_decrement_r3: assert property (@(posedge clk) disable iff (!rstN)
    (str.countEn && !str.reload) |=> cnt == CNT_W'($past(cnt) - 1'b1));
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!str.countEn && !str.reload) |=> $stable(cnt));
endmodule

// File: rtl/winwdog_ctrl.sv
module winwdog_ctrl
  import winwdog_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter logic [7:0]  RESTART_KEY = 8'hA5
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickEn,
  input  logic              idleIn,
  input  logic              dbgIn,
  input  logic [CNT_W-1:0]  cnt,
  output dpStrobe_t         str,
  output logic              irqOut,
  output logic              procRstOut,
  output logic              sysRstOut
);
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;
  localparam logic [DATA_W-1:0] MODE_RST = DATA_W'(32'h3FFF_2FFF);
  localparam int unsigned DLT_LSB  = 16;
  localparam int unsigned B_IRQEN  = 12;
  localparam int unsigned B_RSTEN  = 13;
  localparam int unsigned B_PROC   = 14;
  localparam int unsigned B_DIS    = 15;
  localparam int unsigned B_DBGH   = 28;
  localparam int unsigned B_IDLEH  = 29;
  localparam int unsigned KEY_LSB  = DATA_W - 8;

  logic [DATA_W-1:0] modeReg;
  logic              modeLocked;
  logic [1:0]        statReg;
  logic              rstAct, rstProc;

  logic modeTake, restartStb, statRd, halted, countEn;
  logic faultUf, faultErr, wdDis;
  logic [CNT_W-1:0] reloadVal, deltaVal;

  assign wdDis     = modeReg[B_DIS];
  assign reloadVal = modeReg[CNT_W-1:0];
  assign deltaVal  = modeReg[DLT_LSB +: CNT_W];

  assign modeTake   = busSel && busWr && busAddr == ADDR_MODE && !modeLocked;
  assign restartStb = busSel && busWr && busAddr == ADDR_CTRL && !wdDis &&
                      busWdata[KEY_LSB +: 8] == RESTART_KEY && busWdata[0];
  assign statRd     = busSel && !busWr && busAddr == ADDR_STAT;

  assign halted  = (modeReg[B_IDLEH] && idleIn) || (modeReg[B_DBGH] && dbgIn);
  assign countEn = tickEn && !wdDis && !halted;

  // restart in the same cycle as a tick wins over underflow
  assign faultUf  = countEn && cnt == '0 && !restartStb;
  assign faultErr = restartStb && cnt > deltaVal;

  always_comb begin
    str.countEn = countEn;
    str.reload  = modeTake || restartStb || faultUf;
    str.loadVal = modeTake ? busWdata[CNT_W-1:0] : reloadVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg    <= MODE_RST;
      modeLocked <= 1'b0;
    end else if (modeTake) begin
      modeReg    <= busWdata;
      modeLocked <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statReg <= '0;
    else       statReg <= (statRd ? 2'b00 : statReg) | {faultErr, faultUf};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstAct  <= 1'b0;
      rstProc <= 1'b0;
    end else if ((faultUf || faultErr) && modeReg[B_RSTEN]) begin
      rstAct  <= 1'b1;
      rstProc <= modeReg[B_PROC];
    end else if (tickEn) begin
      rstAct  <= 1'b0;
    end
  end

  assign irqOut     = modeReg[B_IRQEN] && statReg != 2'b00;
  assign procRstOut = rstAct && rstProc;
  assign sysRstOut  = rstAct && !rstProc;

  always_comb begin
    unique case (busAddr)
      ADDR_MODE: busRdata = modeReg;
      ADDR_STAT: busRdata = DATA_W'(statReg);
      ADDR_CNT:  busRdata = DATA_W'(cnt);
      default:   busRdata = '0;
    endcase
  end

  p_mode_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeLocked |=> $stable(modeReg));
  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wdDis && !statRd) |=> $stable(statReg));
  p_rst_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((faultUf || faultErr) && modeReg[B_RSTEN]) |=> (procRstOut || sysRstOut));
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && !faultUf && !faultErr) |=> !irqOut);
  p_err_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    faultErr |=> statReg[1]);
endmodule

// File: rtl/winwdog_top.sv
module winwdog_top
  import winwdog_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter logic [7:0]  RESTART_KEY = 8'hA5
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickEn,
  input  logic              idleIn,
  input  logic              dbgIn,
  output logic              irqOut,
  output logic              procRstOut,
  output logic              sysRstOut
);
  dpStrobe_t        str;
  logic [CNT_W-1:0] cnt;

  winwdog_ctrl #(.DATA_W(DATA_W), .RESTART_KEY(RESTART_KEY)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickEn(tickEn), .idleIn(idleIn), .dbgIn(dbgIn), .cnt(cnt),
    .str(str), .irqOut(irqOut), .procRstOut(procRstOut),
    .sysRstOut(sysRstOut)
  );

  winwdog_dp i_dp (.clk(clk), .rstN(rstN), .str(str), .cnt(cnt));
endmodule

// File: tb/test_winwdog_top.sv
module test_winwdog_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickEn = 1'b0, idleIn = 1'b0, dbgIn = 1'b0;
  logic        irqOut, procRstOut, sysRstOut;

  int nChecks = 0;
  int nErrs = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  winwdog_top i_winwdog_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickEn(tickEn), .idleIn(idleIn), .dbgIn(dbgIn), .irqOut(irqOut),
    .procRstOut(procRstOut), .sysRstOut(sysRstOut)
  );

  always #(CLK_P/2) clk = ~clk;

  // monitor: compare each read against the scoreboard
  always @(negedge clk) begin
    #1;
    if (busSel && !busWr) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nErrs++;
        $display("FAIL unexpected read: act=%h exp=none", busRdata);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (busRdata !== it.val) begin
          nErrs++;
          $display("FAIL %s: act=%h exp=%h", it.tag, busRdata, it.val);
        end
      end
    end
  end

  task automatic readExp(input logic [1:0] a, input logic [31:0] v,
                         input string tag);
    expItem_t it;
    @(negedge clk);
    it.val = v; it.tag = tag;
    expQ.push_back(it);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic chkPin(input string tag, input logic act, input logic exp);
    #1;
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s: act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    nErrs++;
    $display("FAIL watchdog: act=timeout exp=done");
    finish();
  end

  localparam logic [31:0] RESTART = 32'hA500_0001;

  initial begin
    doReset();
    // R1 reset state
    readExp(2'd1, 32'h3FFF_2FFF, "R1 mode reset");
    readExp(2'd2, 32'h0, "R1 status reset");
    readExp(2'd3, 32'hFFF, "R1 count reset");
    readExp(2'd0, 32'h0, "R1 control reads zero");
    chkPin("R1 irq low", irqOut, 1'b0);
    chkPin("R1 sysRst low", sysRstOut, 1'b0);
    chkPin("R1 procRst low", procRstOut, 1'b0);

    // R2 first write: reload 10, delta 4, irq+rst, both halts
    busWrite(2'd1, 32'h3004_300A);
    readExp(2'd1, 32'h3004_300A, "R2 mode written");
    readExp(2'd3, 32'd10, "R2 write reloads count");
    busWrite(2'd1, 32'h0000_8005);
    readExp(2'd1, 32'h3004_300A, "R2 second write ignored");
    readExp(2'd3, 32'd10, "R2 count unaffected");

    // R3 decrement
    ticks(3);
    readExp(2'd3, 32'd7, "R3 count after 3 ticks");

    // R4 wrong key
    busWrite(2'd0, 32'h5A00_0001);
    readExp(2'd3, 32'd7, "R4 wrong key count");
    chkPin("R4 wrong key no irq", irqOut, 1'b0);

    // R5 early restart at 7 > 4
    busWrite(2'd0, RESTART);
    chkPin("R8 sysRst after error", sysRstOut, 1'b1);
    chkPin("R8 procRst stays low", procRstOut, 1'b0);
    chkPin("R7 irq on error", irqOut, 1'b1);
    readExp(2'd3, 32'd10, "R4 restart reloads");
    ticks(1);
    chkPin("R8 pulse ends after tick", sysRstOut, 1'b0);
    readExp(2'd3, 32'd9, "R3 count after tick");
    readExp(2'd2, 32'h2, "R5 error bit");
    readExp(2'd2, 32'h0, "R7 status cleared on read");
    chkPin("R7 irq cleared", irqOut, 1'b0);

    // R5 restart inside window (4 <= 4)
    ticks(5);
    readExp(2'd3, 32'd4, "R3 count at delta");
    busWrite(2'd0, RESTART);
    chkPin("R5 no reset in window", sysRstOut, 1'b0);
    readExp(2'd3, 32'd10, "R4 in-window reload");
    readExp(2'd2, 32'h0, "R5 no fault in window");

    // R10 halts
    idleIn = 1'b1; ticks(3); idleIn = 1'b0;
    readExp(2'd3, 32'd10, "R10 idle halt");
    dbgIn = 1'b1; ticks(3); dbgIn = 1'b0;
    readExp(2'd3, 32'd10, "R10 debug halt");
    ticks(1);
    readExp(2'd3, 32'd9, "R10 resumes");

    // R6 underflow
    ticks(9);
    readExp(2'd3, 32'd0, "R6 count at zero");
    ticks(1);
    chkPin("R8 sysRst after underflow", sysRstOut, 1'b1);
    chkPin("R7 irq after underflow", irqOut, 1'b1);
    readExp(2'd3, 32'd10, "R6 reload after underflow");
    readExp(2'd2, 32'h1, "R6 underflow bit");

    // R8 processor-only reset, no irq: reload 3, delta 3
    doReset();
    busWrite(2'd1, 32'h0003_6003);
    ticks(4);
    chkPin("R8 procRst pulse", procRstOut, 1'b1);
    chkPin("R8 sysRst idle", sysRstOut, 1'b0);
    chkPin("R7 irq disabled", irqOut, 1'b0);
    readExp(2'd3, 32'd3, "R6 reload to 3");
    readExp(2'd2, 32'h1, "R6 status underflow");
    ticks(1);
    chkPin("R8 procRst ends", procRstOut, 1'b0);

    // R9 disabled
    doReset();
    busWrite(2'd1, 32'h0000_A005);
    readExp(2'd3, 32'd5, "R9 loaded count");
    ticks(10);
    readExp(2'd3, 32'd5, "R9 count frozen");
    busWrite(2'd0, RESTART);
    chkPin("R9 no reset", sysRstOut, 1'b0);
    readExp(2'd2, 32'h0, "R9 no fault");

    // R11 restart and tick together at zero
    doReset();
    busWrite(2'd1, 32'h0006_0006);
    ticks(6);
    readExp(2'd3, 32'd0, "R11 count at zero");
    @(negedge clk);
    tickEn = 1'b1; busSel = 1'b1; busWr = 1'b1; busAddr = 2'd0;
    busWdata = RESTART;
    @(negedge clk);
    tickEn = 1'b0; busSel = 1'b0; busWr = 1'b0; busWdata = '0;
    readExp(2'd3, 32'd6, "R11 restart wins");
    readExp(2'd2, 32'h0, "R11 no underflow");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      nErrs++;
      $display("FAIL scoreboard: act=%0d pending exp=0", expQ.size());
    end
    finish();
  end
endmodule